// File: doc/BRIEF.md
# Outbound Address Translation Window Bank

This block holds a small set of programmable outbound windows that map addresses on the local bus side onto addresses on the link side. Each window has a control word (enable, window kind, low part of the size mask), a local base, a 64-bit remote base, and a separate register carrying the upper half of the size mask. Software programs the windows through a simple word-wide register port and may read every register back.

A lookup port accepts a 64-bit local address. Every window compares the address against its own base under its own mask in parallel. The lowest-numbered matching window is chosen, and its translated address is formed from the remote base (masked bits) and the untouched offset bits of the local address. The result is registered, so it appears one cycle after the request. When the chosen window carries configuration requests, the bus, device and function numbers are also broken out of the translated address.

The lookup path has no state machine. It is a flat compare-and-select path followed by one result register. The register port is a plain decode with a registered read path.

Top module: `owin_xlate`

## Requirements
- R1: After reset, every window is disabled, every register reads as zero, `res_valid` is low, and any lookup misses.
- R2: Window w occupies register offsets 16*w (control), 16*w+4 (local base), 16*w+8 (remote base bits 31:0) and 16*w+12 (remote base bits 63:32). Its upper size-mask word sits at 16*NUM_WIN + 4*w. A read asserts `reg_rvalid` with the data exactly one cycle after `reg_re`.
- R3: In the control word, bit 0 is enable and bits 2:1 are the window kind: 0 configuration, 1 I/O, 2 memory. Bits 31:12 are mask bits 31:12. Bits 11:3 are not stored and read as zero.
- R4: Local base bits 1:0 are not stored and read as zero.
- R5: A window hits when it is enabled and (addr & mask) equals (base & mask). The mask is {upper mask word, control bits 31:12, twelve zero bits}, and the local base is zero-extended to 64 bits.
- R6: When several windows hit, the lowest-numbered one is reported.
- R7: The translated address is (remote & mask) | (addr & ~mask).
- R8: For a configuration-kind hit, `res_bus`, `res_dev` and `res_func` are translated-address bits 31:24, 23:19 and 18:16. For any other outcome they are zero.
- R9: `res_valid` follows `lk_valid` by one cycle. On a miss, the hit flag, window index, kind and address are all zero.
- R10: A lookup in the same cycle as a register write sees the contents from before that write. The next lookup sees the new contents.
- R11: Writes to offsets beyond the upper mask words change no register, and reads of those offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after `reg_re` |
| lk_valid | input | 1 | Lookup request |
| lk_addr | input | 64 | Local address to translate |
| res_valid | output | 1 | Lookup result valid |
| res_hit | output | 1 | A window matched |
| res_win | output | 3 | Index of the matching window |
| res_type | output | 2 | Kind of the matching window |
| res_addr | output | 64 | Translated link-side address |
| res_bus | output | 8 | Bus number for configuration hits |
| res_dev | output | 5 | Device number for configuration hits |
| res_func | output | 3 | Function number for configuration hits |

## Verification
A register write and a lookup can fall in the same cycle. The bench provokes this by disabling window 1 in the very cycle it looks up an address that both windows 1 and 2 cover. The result must still name window 1, and a lookup one cycle later must name window 2 with window 2's translation. The bench also reads back a register offset in the same cycle it writes it, and expects the old value.

// File: rtl/owin_pkg.sv
package owin_pkg;

    typedef enum logic [1:0] {
        WT_CFG  = 2'd0,
        WT_IO   = 2'd1,
        WT_MEM  = 2'd2,
        WT_RSVD = 2'd3
    } win_type_e;

    typedef struct packed {
        logic        en;
        win_type_e   wtype;
        logic [63:0] mask;
        logic [31:0] lbase;
        logic [63:0] rbase;
    } win_cfg_t;

    localparam logic [1:0] SLOT_CTRL  = 2'd0;
    localparam logic [1:0] SLOT_LBASE = 2'd1;
    localparam logic [1:0] SLOT_RLO   = 2'd2;
    localparam logic [1:0] SLOT_RHI   = 2'd3;

endpackage

// File: rtl/owin_regs.sv
module owin_regs
    import owin_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int AW        = 8,
    parameter int GRAN_BITS = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_we,
    input  logic          reg_re,
    input  logic [AW-1:0] reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    output logic          reg_rvalid,
    output win_cfg_t      win_cfg [NUM_WIN]
);

    localparam int EXT_BASE = NUM_WIN * 16;
    localparam int GAP_W    = GRAN_BITS - 3;

    logic [NUM_WIN-1:0][31:0] rd_word;
    logic [31:0]              rd_mux;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        localparam logic [AW-1:0] MAIN_ADDR = AW'(w * 16);
        localparam logic [AW-1:0] EXT_ADDR  = AW'(EXT_BASE + w * 4);

        logic                  main_sel;
        logic                  ext_sel;
        logic                  en_q;
        win_type_e             type_q;
        logic [31:GRAN_BITS]   mask_lo_q;
        logic [31:0]           mask_hi_q;
        logic [31:2]           lbase_q;
        logic [63:0]           rbase_q;
        logic [31:0]           main_word;

        assign main_sel = (reg_addr[AW-1:4] == MAIN_ADDR[AW-1:4]);
        assign ext_sel  = (reg_addr[AW-1:2] == EXT_ADDR[AW-1:2]);

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                en_q      <= 1'b0;
                type_q    <= WT_CFG;
                mask_lo_q <= '0;
                mask_hi_q <= '0;
                lbase_q   <= '0;
                rbase_q   <= '0;
            end else begin
                if (reg_we && main_sel) begin
                    unique case (reg_addr[3:2])
                        SLOT_CTRL: begin
                            en_q      <= reg_wdata[0];
                            type_q    <= win_type_e'(reg_wdata[2:1]);
                            mask_lo_q <= reg_wdata[31:GRAN_BITS];
                        end
                        SLOT_LBASE: lbase_q        <= reg_wdata[31:2];
                        SLOT_RLO:   rbase_q[31:0]  <= reg_wdata;
                        SLOT_RHI:   rbase_q[63:32] <= reg_wdata;
                    endcase
                end
                if (reg_we && ext_sel) begin
                    mask_hi_q <= reg_wdata;
                end
            end
        end

        always_comb begin
            unique case (reg_addr[3:2])
                SLOT_CTRL:  main_word = {mask_lo_q, {GAP_W{1'b0}}, type_q, en_q};
                SLOT_LBASE: main_word = {lbase_q, 2'b00};
                SLOT_RLO:   main_word = rbase_q[31:0];
                SLOT_RHI:   main_word = rbase_q[63:32];
            endcase
        end

        assign rd_word[w] = main_sel ? main_word : (ext_sel ? mask_hi_q : 32'h0);

        assign win_cfg[w] = {en_q, type_q,
                             {mask_hi_q, mask_lo_q, {GRAN_BITS{1'b0}}},
                             {lbase_q, 2'b00}, rbase_q};
    end

    always_comb begin
        rd_mux = '0;
        for (int w = 0; w < NUM_WIN; w++) begin
            rd_mux = rd_mux | rd_word[w];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_re;
            reg_rdata  <= reg_re ? rd_mux : 32'h0;
        end
    end

endmodule

// File: rtl/owin_match.sv
module owin_match
    import owin_pkg::*;
(
    input  win_cfg_t    cfg,
    input  logic [63:0] addr,
    output logic        hit,
    output logic [63:0] xaddr
);

    logic [63:0] base64;

    assign base64 = {32'h0, cfg.lbase};
    assign hit    = cfg.en && ((addr & cfg.mask) == (base64 & cfg.mask));
    assign xaddr  = (cfg.rbase & cfg.mask) | (addr & ~cfg.mask);

endmodule

// File: rtl/owin_select.sv
module owin_select
    import owin_pkg::*;
#(
    parameter int NUM_WIN = 8,
    localparam int IDX_W  = $clog2(NUM_WIN)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     lk_valid,
    input  logic [NUM_WIN-1:0]       hit_vec,
    input  logic [NUM_WIN-1:0][63:0] xaddr_vec,
    input  logic [NUM_WIN-1:0][1:0]  type_vec,
    output logic                     res_valid,
    output logic                     res_hit,
    output logic [IDX_W-1:0]         res_win,
    output logic [1:0]               res_type,
    output logic [63:0]              res_addr,
    output logic [7:0]               res_bus,
    output logic [4:0]               res_dev,
    output logic [2:0]               res_func
);

    logic             found;
    logic [IDX_W-1:0] sel_idx;
    logic [63:0]      sel_addr;
    win_type_e        sel_type;
    logic             is_cfg;

    always_comb begin
        found   = 1'b0;
        sel_idx = '0;
        for (int w = NUM_WIN - 1; w >= 0; w--) begin
            if (hit_vec[w]) begin
                found   = 1'b1;
                sel_idx = IDX_W'(w);
            end
        end
        sel_addr = xaddr_vec[sel_idx];
        sel_type = win_type_e'(type_vec[sel_idx]);
        is_cfg   = found && (sel_type == WT_CFG);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_win   <= '0;
            res_type  <= '0;
            res_addr  <= '0;
            res_bus   <= '0;
            res_dev   <= '0;
            res_func  <= '0;
        end else begin
            res_valid <= lk_valid;
            if (lk_valid && found) begin
                res_hit  <= 1'b1;
                res_win  <= sel_idx;
                res_type <= sel_type;
                res_addr <= sel_addr;
                res_bus  <= is_cfg ? sel_addr[31:24] : 8'h0;
                res_dev  <= is_cfg ? sel_addr[23:19] : 5'h0;
                res_func <= is_cfg ? sel_addr[18:16] : 3'h0;
            end else begin
                res_hit  <= 1'b0;
                res_win  <= '0;
                res_type <= '0;
                res_addr <= '0;
                res_bus  <= '0;
                res_dev  <= '0;
                res_func <= '0;
            end
        end
    end

endmodule

// File: rtl/owin_xlate.sv
module owin_xlate
    import owin_pkg::*;
#(
    parameter int NUM_WIN   = 8,
    parameter int AW        = 8,
    parameter int GRAN_BITS = 12,
    localparam int IDX_W    = $clog2(NUM_WIN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic             reg_re,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             reg_rvalid,
    input  logic             lk_valid,
    input  logic [63:0]      lk_addr,
    output logic             res_valid,
    output logic             res_hit,
    output logic [IDX_W-1:0] res_win,
    output logic [1:0]       res_type,
    output logic [63:0]      res_addr,
    output logic [7:0]       res_bus,
    output logic [4:0]       res_dev,
    output logic [2:0]       res_func
);

    win_cfg_t                 win_cfg [NUM_WIN];
    logic [NUM_WIN-1:0]       hit_vec;
    logic [NUM_WIN-1:0][63:0] xaddr_vec;
    logic [NUM_WIN-1:0][1:0]  type_vec;

    owin_regs #(
        .NUM_WIN   (NUM_WIN),
        .AW        (AW),
        .GRAN_BITS (GRAN_BITS)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .win_cfg    (win_cfg)
    );

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
        owin_match u_match (
            .cfg   (win_cfg[w]),
            .addr  (lk_addr),
            .hit   (hit_vec[w]),
            .xaddr (xaddr_vec[w])
        );
        assign type_vec[w] = win_cfg[w].wtype;
    end

    owin_select #(
        .NUM_WIN (NUM_WIN)
    ) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_valid  (lk_valid),
        .hit_vec   (hit_vec),
        .xaddr_vec (xaddr_vec),
        .type_vec  (type_vec),
        .res_valid (res_valid),
        .res_hit   (res_hit),
        .res_win   (res_win),
        .res_type  (res_type),
        .res_addr  (res_addr),
        .res_bus   (res_bus),
        .res_dev   (res_dev),
        .res_func  (res_func)
    );

endmodule

// File: rtl/owin_xlate_chk.sv
module owin_xlate_chk #(
    parameter int IDX_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_re,
    input logic             reg_rvalid,
    input logic             lk_valid,
    input logic             res_valid,
    input logic             res_hit,
    input logic [IDX_W-1:0] res_win,
    input logic [1:0]       res_type,
    input logic [63:0]      res_addr,
    input logic [7:0]       res_bus,
    input logic [4:0]       res_dev,
    input logic [2:0]       res_func
);

    // R2
    rd_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> reg_rvalid);

    // R2
    rd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_re |=> !reg_rvalid);

    // R9
    res_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lk_valid |=> res_valid);

    // R9
    res_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_valid |=> (!res_valid && !res_hit));

    // R9
    miss_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_hit) |-> (res_addr == 64'h0 && res_win == '0 && res_type == 2'd0));

    // R8
    bdf_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!res_hit || res_type != 2'd0) |-> (res_bus == 8'h0 && res_dev == 5'h0 && res_func == 3'h0));

    // R8
    bdf_field_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_hit && res_type == 2'd0) |-> (res_bus == res_addr[31:24] && res_dev == res_addr[23:19]
                                           && res_func == res_addr[18:16]));

endmodule

bind owin_xlate owin_xlate_chk #(
    .IDX_W (IDX_W)
) u_owin_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_re     (reg_re),
    .reg_rvalid (reg_rvalid),
    .lk_valid   (lk_valid),
    .res_valid  (res_valid),
    .res_hit    (res_hit),
    .res_win    (res_win),
    .res_type   (res_type),
    .res_addr   (res_addr),
    .res_bus    (res_bus),
    .res_dev    (res_dev),
    .res_func   (res_func)
);

// File: tb/test_owin_xlate.sv
module test_owin_xlate;

    localparam int CLK_PERIOD = 10;
    localparam int N_PROG     = 24;
    localparam int N_VEC      = 9;

    // {reg offset, data}
    localparam logic [39:0] PROG [N_PROG] = '{
        {8'h00, 32'hFFFF_FFF9}, {8'h04, 32'h4000_0003}, {8'h08, 32'h032A_0000}, {8'h0C, 32'h0},
        {8'h80, 32'hFFFF_FFFF},
        {8'h10, 32'hFFF0_0005}, {8'h14, 32'h5000_0000}, {8'h18, 32'h3400_0000}, {8'h1C, 32'h12},
        {8'h84, 32'hFFFF_FFFF},
        {8'h20, 32'hFFFF_0003}, {8'h24, 32'h5001_0000}, {8'h28, 32'h00A0_0000}, {8'h2C, 32'h0},
        {8'h88, 32'hFFFF_FFFF},
        {8'h40, 32'hFFFF_F004}, {8'h44, 32'h6000_0000}, {8'h48, 32'h7700_0000},
        {8'h90, 32'hFFFF_FFFF},
        {8'h70, 32'h0000_0005}, {8'h74, 32'h0}, {8'h78, 32'h0}, {8'h7C, 32'h100},
        {8'h9C, 32'hFFFF_FFFF}
    };

    // {lookup addr, hit, window, kind, translated addr}
    localparam logic [133:0] VEC [N_VEC] = '{
        {64'h0000_0000_4000_0ABC, 1'b1, 3'd0, 2'd0, 64'h0000_0000_032A_0ABC},
        {64'h0000_0000_5001_2345, 1'b1, 3'd1, 2'd2, 64'h0000_0012_3401_2345},
        {64'h0000_0000_5001_0000, 1'b1, 3'd1, 2'd2, 64'h0000_0012_3401_0000},
        {64'h0000_0000_5020_0000, 1'b1, 3'd7, 2'd2, 64'h0000_0100_5020_0000},
        {64'h0000_0000_6000_0010, 1'b1, 3'd7, 2'd2, 64'h0000_0100_6000_0010},
        {64'h0000_0001_0000_0000, 1'b0, 3'd0, 2'd0, 64'h0},
        {64'h0000_0000_4000_0FFF, 1'b1, 3'd0, 2'd0, 64'h0000_0000_032A_0FFF},
        {64'h0000_0000_4000_1000, 1'b1, 3'd7, 2'd2, 64'h0000_0100_4000_1000},
        {64'hFFFF_FFFF_4000_0000, 1'b0, 3'd0, 2'd0, 64'h0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic        reg_re = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_rvalid;
    logic        lk_valid = 1'b0;
    logic [63:0] lk_addr = '0;
    logic        res_valid;
    logic        res_hit;
    logic [2:0]  res_win;
    logic [1:0]  res_type;
    logic [63:0] res_addr;
    logic [7:0]  res_bus;
    logic [4:0]  res_dev;
    logic [2:0]  res_func;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    owin_xlate i_owin_xlate (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_re     (reg_re),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .reg_rvalid (reg_rvalid),
        .lk_valid   (lk_valid),
        .lk_addr    (lk_addr),
        .res_valid  (res_valid),
        .res_hit    (res_hit),
        .res_win    (res_win),
        .res_type   (res_type),
        .res_addr   (res_addr),
        .res_bus    (res_bus),
        .res_dev    (res_dev),
        .res_func   (res_func)
    );

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(negedge clk);
        reg_we    = 1'b0;
    endtask

    task automatic reg_rd(input logic [7:0] a, input logic [31:0] exp, input string req);
        @(negedge clk);
        reg_re   = 1'b1;
        reg_addr = a;
        @(negedge clk);
        reg_re   = 1'b0;
        check(req, "rvalid", 64'(reg_rvalid), 64'h1);
        check(req, "rdata", 64'(reg_rdata), 64'(exp));
    endtask

    task automatic lookup(input logic [63:0] a, input logic exp_hit, input logic [2:0] exp_win,
                          input logic [1:0] exp_type, input logic [63:0] exp_addr);
        logic [7:0] eb;
        logic [4:0] ed;
        logic [2:0] ef;
        @(negedge clk);
        lk_valid = 1'b1;
        lk_addr  = a;
        @(negedge clk);
        lk_valid = 1'b0;
        eb = (exp_hit && exp_type == 2'd0) ? exp_addr[31:24] : 8'h0;
        ed = (exp_hit && exp_type == 2'd0) ? exp_addr[23:19] : 5'h0;
        ef = (exp_hit && exp_type == 2'd0) ? exp_addr[18:16] : 3'h0;
        check("R9", "res_valid", 64'(res_valid), 64'h1);
        check("R5", "res_hit", 64'(res_hit), 64'(exp_hit));
        check("R6", "res_win", 64'(res_win), 64'(exp_win));
        check("R3", "res_type", 64'(res_type), 64'(exp_type));
        check("R7", "res_addr", res_addr, exp_addr);
        check("R8", "bdf", {39'h0, res_bus, res_dev, res_func}, {39'h0, eb, ed, ef});
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        check("R1", "res_valid after reset", 64'(res_valid), 64'h0);
        reg_rd(8'h00, 32'h0, "R1");
        reg_rd(8'h80, 32'h0, "R1");
        lookup(64'h0, 1'b0, 3'd0, 2'd0, 64'h0);

        for (int i = 0; i < N_PROG; i++) begin
            reg_wr(PROG[i][39:32], PROG[i][31:0]);
        end

        // R2 R3 R4 readback
        reg_rd(8'h00, 32'hFFFF_F001, "R3");
        reg_rd(8'h04, 32'h4000_0000, "R4");
        reg_rd(8'h28, 32'h00A0_0000, "R2");
        reg_rd(8'h1C, 32'h0000_0012, "R2");
        reg_rd(8'h88, 32'hFFFF_FFFF, "R2");
        reg_rd(8'h8C, 32'h0, "R2");

        // R5 R6 R7 R8: vector table
        for (int i = 0; i < N_VEC; i++) begin
            lookup(VEC[i][133:70], VEC[i][69], VEC[i][68:66], VEC[i][65:64], VEC[i][63:0]);
        end

        // R11: write beyond the map is ignored
        reg_wr(8'hA0, 32'hDEAD_BEEF);
        reg_rd(8'hA0, 32'h0, "R11");
        reg_rd(8'h9C, 32'hFFFF_FFFF, "R11");
        reg_rd(8'h00, 32'hFFFF_F001, "R11");
        lookup(64'h4000_0ABC, 1'b1, 3'd0, 2'd0, 64'h032A_0ABC);

        // R10: write disabling window 1 in the same cycle as a lookup
        @(negedge clk);
        reg_we    = 1'b1;
        reg_addr  = 8'h10;
        reg_wdata = 32'hFFF0_0004;
        lk_valid  = 1'b1;
        lk_addr   = 64'h5001_2345;
        @(negedge clk);
        reg_we    = 1'b0;
        lk_valid  = 1'b0;
        check("R10", "same-cycle win", 64'(res_win), 64'd1);
        check("R10", "same-cycle addr", res_addr, 64'h0000_0012_3401_2345);
        lookup(64'h5001_2345, 1'b1, 3'd2, 2'd1, 64'h00A0_2345);

        // R10: read and write the same offset in one cycle returns the old value
        @(negedge clk);
        reg_we    = 1'b1;
        reg_re    = 1'b1;
        reg_addr  = 8'h18;
        reg_wdata = 32'h5555_0000;
        @(negedge clk);
        reg_we    = 1'b0;
        reg_re    = 1'b0;
        check("R10", "read during write", 64'(reg_rdata), 64'h3400_0000);
        reg_rd(8'h18, 32'h5555_0000, "R10");

        // R9: idle cycle yields no result
        @(negedge clk);
        check("R9", "res_valid idle", 64'(res_valid), 64'h0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule